// File: doc/BRIEF.md
# Battery-Backed Calendar Clock with Indexed Byte Store

This block keeps wall-clock time and date in a 128-byte store and gives a processor access to it through two byte-wide I/O locations. The processor writes a byte index to the first location. It then reads or writes the selected byte through the second location. A separate 32-bit management write port fills the store before use and sets two cycle-count constants. One constant is the number of clock cycles in one second. The other is the number of cycles in one periodic-interrupt interval.

Once per second the block advances the BCD seconds, minutes, hours, weekday, day of month, month and year, held in their fixed byte slots. It raises the interrupt line on periodic, alarm or update events, but only when software has enabled them. Control byte 0x0B carries a freeze bit that stops the time from advancing. Status byte 0x0C holds the event flags, and reading it clears them.

Top module: `cmos_rtc`

## Requirements
- R1: An I/O write with `io_addr`=0 loads bits 6:0 of the data into the byte index. An I/O read with `io_addr`=0 returns `{1'b0, index}`. An I/O read or write with `io_addr`=1 accesses the byte at the current index. Every index from 0x0E to 0x7F is plain storage that reads back what was last written.
- R2: A management write to addresses 0 to 127 stores bits 7:0 of `mgmt_wdata` into that byte of the store.
- R3: A management write to address 128 sets the cycles-per-second count from bits 26:0. A write to address 129 sets the periodic count from bits 12:0. While the freeze bit is clear, exactly one time update happens in every window of consecutive cycles that is as long as the seconds count.
- R4: Read data is registered. It appears on `io_rdata` after the clock edge that samples `io_rd`, and it holds until the next read.
- R5: The update advances the time fields. These are BCD, and the hour uses a 24-hour clock. Seconds are at 0x00, minutes at 0x02, hours at 0x04, weekday at 0x06 (1 to 7, wrapping 7 to 1), day of month at 0x07, month at 0x08 and year at 0x09 (00 to 99). Each field carries into the next, and day and month restart at 01.
- R6: The last day of a month is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on day 29 when the year is divisible by 4 and on day 28 otherwise.
- R7: While bit 7 of byte 0x0B (freeze) is 1, no time field changes except by an explicit write.
- R8: Reading byte 0x0A returns an update-pending flag in bit 7 and the stored bits 6:0. The flag is 1 in the last few cycles before each update and is never 1 while freeze is set.
- R9: Byte 0x0C reads as {IRQ, periodic, alarm, update, 0000}. The periodic flag sets on every periodic interval. The update flag sets on every time update. The alarm flag sets on an update whose new seconds, minutes and hours equal the bytes at 0x01, 0x03 and 0x05.
- R10: Reading byte 0x0C returns the flags and then clears them, which drops `irq`.
- R11: `irq` and flag bit 7 are 1 only when a set flag has its enable bit set in byte 0x0B: bit 6 enables periodic, bit 5 enables alarm, bit 4 enables update.
- R12: Byte 0x0D always reads 0x80. I/O writes to bytes 0x0C and 0x0D have no effect.
- R13: Reset clears the index, the cycle counters, the flags and `irq`, and leaves the byte store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | output | 1 | Interrupt request |
| io_addr | input | 1 | 0 selects the index, 1 selects the data byte |
| io_rd | input | 1 | One-cycle read strobe |
| io_rdata | output | 8 | Registered read data |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| mgmt_addr | input | 8 | Management address: 0 to 127 for store bytes, 128 and 129 for the constants |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_wdata | input | 32 | Management write data |

## Verification
Some behaviour is checked on every cycle by properties:
- the cycle counters wrap at their limits;
- the update-pending flag is always high in the cycle before an unfrozen rollover;
- a status read empties the flags;
- a raised interrupt persists until it is read or disabled;
- the seconds byte stays still while frozen.

The calendar arithmetic can only be shown by scenarios: month ends, leap February and the end-of-century wrap. The same holds for alarm matching, the read-to-clear ordering and retention across reset. The bench covers these with directed dates and randomised dates, and compares the result with its own date model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [6:0] IX_SEC  = 7'h00;
  localparam logic [6:0] IX_ASEC = 7'h01;
  localparam logic [6:0] IX_MIN  = 7'h02;
  localparam logic [6:0] IX_AMIN = 7'h03;
  localparam logic [6:0] IX_HR   = 7'h04;
  localparam logic [6:0] IX_AHR  = 7'h05;
  localparam logic [6:0] IX_DOW  = 7'h06;
  localparam logic [6:0] IX_DOM  = 7'h07;
  localparam logic [6:0] IX_MON  = 7'h08;
  localparam logic [6:0] IX_YR   = 7'h09;
  localparam logic [6:0] IX_STA  = 7'h0A;
  localparam logic [6:0] IX_CTL  = 7'h0B;
  localparam logic [6:0] IX_FLG  = 7'h0C;
  localparam logic [6:0] IX_VLD  = 7'h0D;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t rtc_next(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) begin
      n.sec = bcd_inc(t.sec);
    end else begin
      n.sec = 8'h00;
      if (t.mins != 8'h59) begin
        n.mins = bcd_inc(t.mins);
      end else begin
        n.mins = 8'h00;
        if (t.hr != 8'h23) begin
          n.hr = bcd_inc(t.hr);
        end else begin
          n.hr  = 8'h00;
          n.dow = (t.dow >= 8'h07) ? 8'h01 : t.dow + 8'h01;
          if (t.dom != last_day(t.mon, t.yr)) begin
            n.dom = bcd_inc(t.dom);
          end else begin
            n.dom = 8'h01;
            if (t.mon != 8'h12) begin
              n.mon = bcd_inc(t.mon);
            end else begin
              n.mon = 8'h01;
              n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int          SEC_W   = 27,
  parameter int          PER_W   = 13,
  parameter int          UIP_CYC = 8,
  parameter int unsigned SEC_RST = 50_000_000,
  parameter int unsigned PER_RST = 6104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_ld_i,
  input  logic        per_ld_i,
  input  logic [31:0] ld_val_i,
  input  logic        hold_i,
  output logic        sec_tick_o,
  output logic        per_tick_o,
  output logic        uip_o
);

  localparam logic [SEC_W-1:0] UIP_LIM = SEC_W'(UIP_CYC);

  logic [SEC_W-1:0] sec_lim_q, sec_lim_d, sec_cnt_q, sec_cnt_d, sec_rem;
  logic [PER_W-1:0] per_lim_q, per_lim_d, per_cnt_q, per_cnt_d;
  logic             unused_hi;

  assign unused_hi = ^ld_val_i[31:SEC_W];

  assign sec_tick_o = ({1'b0, sec_cnt_q} + 1'b1) >= {1'b0, sec_lim_q};
  assign per_tick_o = ({1'b0, per_cnt_q} + 1'b1) >= {1'b0, per_lim_q};
  assign sec_rem    = sec_lim_q - sec_cnt_q;
  assign uip_o      = !hold_i && (sec_lim_q > sec_cnt_q) && (sec_rem <= UIP_LIM);

  always_comb begin
    sec_cnt_d = sec_tick_o ? '0 : sec_cnt_q + 1'b1;
    per_cnt_d = per_tick_o ? '0 : per_cnt_q + 1'b1;
    sec_lim_d = sec_ld_i ? ld_val_i[SEC_W-1:0] : sec_lim_q;
    per_lim_d = per_ld_i ? ld_val_i[PER_W-1:0] : per_lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt_q <= '0;
      per_cnt_q <= '0;
      sec_lim_q <= SEC_W'(SEC_RST);
      per_lim_q <= PER_W'(PER_RST);
    end else begin
      sec_cnt_q <= sec_cnt_d;
      per_cnt_q <= per_cnt_d;
      sec_lim_q <= sec_lim_d;
      per_lim_q <= per_lim_d;
    end
  end

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_cnt_q >= sec_lim_q) |=> (sec_cnt_q == '0));

  // R3
  per_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cnt_q >= per_lim_q) |=> (per_cnt_q == '0));

  // R8
  uip_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick_o && !hold_i && $past(!hold_i) && $stable(sec_lim_q) &&
     (sec_lim_q > UIP_LIM + 1'b1)) |-> $past(uip_o));

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_evt_i,
  input  logic       alm_evt_i,
  input  logic       upd_evt_i,
  input  logic [2:0] en_i,
  input  logic       clr_i,
  output logic [2:0] flags_o,
  output logic       irq_o
);

  logic [2:0] flags_q, flags_d, evt;

  assign evt     = {per_evt_i, alm_evt_i, upd_evt_i};
  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  always_comb begin
    flags_d = (clr_i ? 3'b000 : flags_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (evt == 3'b000)) |=> ((flags_q == 3'b000) && !irq_o));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_o) && !$past(clr_i) && $stable(en_i)) |-> irq_o);

endmodule

// File: rtl/cmos_rtc.sv
module cmos_rtc #(
  parameter int SEC_W   = 27,
  parameter int PER_W   = 13,
  parameter int UIP_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        irq,
  input  logic        io_addr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  input  logic [7:0]  mgmt_addr,
  input  logic        mgmt_wr,
  input  logic [31:0] mgmt_wdata
);
  import rtc_pkg::*;

  localparam int          BYTES   = 128;
  localparam logic [7:0]  SEC_ADR = 8'(BYTES);
  localparam logic [7:0]  PER_ADR = 8'(BYTES + 1);

  logic [7:0] ram_q [BYTES];
  logic [6:0] idx_q, idx_d;
  logic [7:0] rdata_q, rdata_d;
  logic       sec_tick, per_tick, uip, irq_w, freeze, upd, alm_hit;
  logic       sec_ld, per_ld, mgmt_ram_we, io_ram_we, flg_clr;
  logic [2:0] flags, irq_en;
  rtc_time_t  cur_t, nxt_t;

  assign freeze = ram_q[IX_CTL][7];
  assign irq_en = ram_q[IX_CTL][6:4];

  assign cur_t = '{yr: ram_q[IX_YR], mon: ram_q[IX_MON], dom: ram_q[IX_DOM],
                   dow: ram_q[IX_DOW], hr: ram_q[IX_HR], mins: ram_q[IX_MIN],
                   sec: ram_q[IX_SEC]};
  assign nxt_t = rtc_next(cur_t);

  assign upd     = sec_tick && !freeze;
  assign alm_hit = upd && (nxt_t.sec == ram_q[IX_ASEC]) &&
                   (nxt_t.mins == ram_q[IX_AMIN]) && (nxt_t.hr == ram_q[IX_AHR]);

  assign mgmt_ram_we = mgmt_wr && !mgmt_addr[7];
  assign sec_ld      = mgmt_wr && (mgmt_addr == SEC_ADR);
  assign per_ld      = mgmt_wr && (mgmt_addr == PER_ADR);
  assign io_ram_we   = io_wr && io_addr && (idx_q != IX_FLG) && (idx_q != IX_VLD);
  assign flg_clr     = io_rd && io_addr && (idx_q == IX_FLG);

  rtc_tick_gen #(
    .SEC_W(SEC_W), .PER_W(PER_W), .UIP_CYC(UIP_CYC)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .sec_ld_i(sec_ld), .per_ld_i(per_ld),
    .ld_val_i(mgmt_wdata), .hold_i(freeze), .sec_tick_o(sec_tick),
    .per_tick_o(per_tick), .uip_o(uip)
  );

  rtc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_evt_i(per_tick), .alm_evt_i(alm_hit),
    .upd_evt_i(upd), .en_i(irq_en), .clr_i(flg_clr), .flags_o(flags),
    .irq_o(irq_w)
  );

  assign irq      = irq_w;
  assign io_rdata = rdata_q;

  always_comb begin
    idx_d   = (io_wr && !io_addr) ? io_wdata[6:0] : idx_q;
    rdata_d = rdata_q;
    if (io_rd) begin
      if (!io_addr) begin
        rdata_d = {1'b0, idx_q};
      end else begin
        case (idx_q)
          IX_STA:  rdata_d = {uip, ram_q[IX_STA][6:0]};
          IX_FLG:  rdata_d = {irq_w, flags, 4'b0000};
          IX_VLD:  rdata_d = 8'h80;
          default: rdata_d = ram_q[idx_q];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  // byte store: no reset, later statements take priority
  always_ff @(posedge clk) begin
    if (upd) begin
      ram_q[IX_SEC] <= nxt_t.sec;
      ram_q[IX_MIN] <= nxt_t.mins;
      ram_q[IX_HR]  <= nxt_t.hr;
      ram_q[IX_DOW] <= nxt_t.dow;
      ram_q[IX_DOM] <= nxt_t.dom;
      ram_q[IX_MON] <= nxt_t.mon;
      ram_q[IX_YR]  <= nxt_t.yr;
    end
    if (io_ram_we)   ram_q[idx_q]           <= io_wdata;
    if (mgmt_ram_we) ram_q[mgmt_addr[6:0]]  <= mgmt_wdata[7:0];
  end

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && !$past(mgmt_wr) && !$past(io_wr)) |-> $stable(ram_q[IX_SEC]));

endmodule

// File: tb/cmos_rtc_tb_top.sv
module cmos_rtc_tb_top;

  localparam int LIM = 20;
  localparam int PLIM = 7;

  logic        clk, rst_n, irq, io_addr, io_rd, io_wr, mgmt_wr;
  logic [7:0]  io_rdata, io_wdata, mgmt_addr;
  logic [31:0] mgmt_wdata;
  int checks, fails;

  cmos_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .io_addr(io_addr), .io_rd(io_rd),
    .io_rdata(io_rdata), .io_wr(io_wr), .io_wdata(io_wdata),
    .mgmt_addr(mgmt_addr), .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic mg_wr(input int a, input int d);
    mgmt_addr = 8'(a); mgmt_wdata = 32'(d); mgmt_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic io_write(input logic a, input int d);
    io_addr = a; io_wdata = 8'(d); io_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic a, output int v);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    io_rd = 1'b0;
    v = int'(io_rdata);
  endtask

  task automatic reg_wr(input int ix, input int d);
    io_write(1'b0, ix); io_write(1'b1, d);
  endtask

  task automatic reg_rd(input int ix, output int v);
    io_write(1'b0, ix); io_read(1'b1, v);
  endtask

  function automatic int b2i(input int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int i2b(input int i); return ((i / 10) << 4) | (i % 10); endfunction
  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // binary model of one-second advance; fields in t[0..6] = sec,min,hr,dow,dom,mon,yr
  function automatic void model_next(ref int t[7]);
    t[0]++;
    if (t[0] < 60) return;
    t[0] = 0; t[1]++;
    if (t[1] < 60) return;
    t[1] = 0; t[2]++;
    if (t[2] < 24) return;
    t[2] = 0; t[3] = (t[3] % 7) + 1; t[4]++;
    if (t[4] <= mdays(t[5], t[6])) return;
    t[4] = 1; t[5]++;
    if (t[5] <= 12) return;
    t[5] = 1; t[6] = (t[6] + 1) % 100;
  endfunction

  int slot[7] = '{0, 2, 4, 6, 7, 8, 9};

  // freeze clear for exactly LIM edges, then freeze again
  task automatic one_window(input int en);
    io_write(1'b0, 8'h0B);
    io_write(1'b1, en);
    repeat (LIM - 1) @(negedge clk);
    io_write(1'b1, 8'h80 | en);
  endtask

  task automatic date_case(input string req, input int s, input int mi, input int h,
                           input int w, input int d, input int mo, input int y);
    int t[7];
    int v;
    t = '{s, mi, h, w, d, mo, y};
    for (int k = 0; k < 7; k++) mg_wr(slot[k], (k == 3) ? t[k] : i2b(t[k]));
    mg_wr(8'h0B, 8'h80);
    one_window(0);
    model_next(t);
    for (int k = 0; k < 7; k++) begin
      reg_rd(slot[k], v);
      chk(req, v, (k == 3) ? t[k] : i2b(t[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int v, s1, s0, ix, dv, mo, y;
    void'($urandom(32'd2718));
    checks = 0; fails = 0;
    rst_n = 1'b0; io_addr = 1'b0; io_rd = 1'b0; io_wr = 1'b0; io_wdata = '0;
    mgmt_addr = '0; mgmt_wr = 1'b0; mgmt_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 irq after reset", int'(irq), 0);
    chk("R13 rdata after reset", int'(io_rdata), 0);
    io_read(1'b0, v);
    chk("R13 index after reset", v, 0);

    mg_wr(128, LIM);
    mg_wr(129, PLIM);
    mg_wr(8'h0B, 8'h80);

    // R2 / R1: management preload then I/O read, I/O write then read
    for (int k = 0; k < 8; k++) begin
      ix = 14 + int'($urandom % 114);
      dv = int'($urandom % 256);
      mg_wr(ix, dv);
      reg_rd(ix, v);
      chk("R2 preload", v, dv);
      dv = int'($urandom % 256);
      reg_wr(ix, dv);
      reg_rd(ix, v);
      chk("R1 io store", v, dv);
    end
    io_write(1'b0, 8'h5C);
    io_read(1'b0, v);
    chk("R1 index read", v, 8'h5C);
    io_write(1'b0, 8'hF3);
    io_read(1'b0, v);
    chk("R1 index bit7 dropped", v, 8'h73);

    // R4: data registered and held
    mg_wr(8'h40, 8'hA5);
    reg_rd(8'h40, v);
    repeat (5) @(negedge clk);
    chk("R4 read data held", int'(io_rdata), 8'hA5);

    // R12
    reg_rd(8'h0D, v);
    chk("R12 valid byte", v, 8'h80);
    reg_wr(8'h0D, 8'h00);
    reg_rd(8'h0D, v);
    chk("R12 valid byte write ignored", v, 8'h80);

    // R5 / R6 directed dates
    date_case("R5 carry all", 59, 59, 23, 7, 31, 12, 99);
    date_case("R6 leap feb 28", 59, 59, 23, 3, 28, 2, 24);
    date_case("R6 leap feb 29", 59, 59, 23, 4, 29, 2, 24);
    date_case("R6 common feb 28", 59, 59, 23, 2, 28, 2, 23);
    date_case("R6 april 30", 59, 59, 23, 5, 30, 4, 21);
    date_case("R5 minute carry", 59, 12, 8, 2, 15, 6, 50);

    // R5 / R3 random dates (one update per window)
    for (int k = 0; k < 20; k++) begin
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      date_case("R5 random date",
                ($urandom % 2) ? 59 : int'($urandom % 60),
                ($urandom % 2) ? 59 : int'($urandom % 60),
                ($urandom % 2) ? 23 : int'($urandom % 24),
                1 + int'($urandom % 7),
                ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y)),
                mo, y);
    end

    // R7: frozen for several seconds, nothing moves
    mg_wr(8'h00, 8'h17);
    repeat (3 * LIM) @(negedge clk);
    reg_rd(8'h00, v);
    chk("R7 frozen seconds", v, 8'h17);

    // R8: update-pending flag
    io_write(1'b0, 8'h0B); io_write(1'b1, 8'h00);
    io_write(1'b0, 8'h0A);
    s1 = 0; s0 = 0;
    for (int k = 0; k < 2 * LIM; k++) begin
      io_read(1'b1, v);
      if (v[7]) s1++; else s0++;
    end
    chk("R8 pending seen", int'(s1 > 0 && s0 > 0), 1);
    io_write(1'b0, 8'h0B); io_write(1'b1, 8'h80);
    io_write(1'b0, 8'h0A);
    s1 = 0;
    for (int k = 0; k < 2 * LIM; k++) begin
      io_read(1'b1, v);
      if (v[7]) s1++;
    end
    chk("R8 pending while frozen", s1, 0);

    // R11: enables off, irq silent over an update
    reg_rd(8'h0C, v);
    one_window(0);
    chk("R11 irq without enables", int'(irq), 0);

    // R9 / R10 / R11 update interrupt
    reg_rd(8'h0C, v);
    one_window(8'h10);
    chk("R11 irq with update enable", int'(irq), 1);
    reg_rd(8'h0C, v);
    chk("R9 update flag and irq bit", v & 8'h90, 8'h90);
    chk("R10 irq dropped after read", int'(irq), 0);
    reg_rd(8'h0C, v);
    chk("R10 update flag cleared", v & 8'h90, 8'h00);

    // R9 alarm
    mg_wr(8'h00, 8'h30); mg_wr(8'h02, 8'h20); mg_wr(8'h04, 8'h10);
    mg_wr(8'h01, 8'h31); mg_wr(8'h03, 8'h20); mg_wr(8'h05, 8'h10);
    mg_wr(8'h0B, 8'h80);
    reg_rd(8'h0C, v);
    one_window(8'h20);
    chk("R9 alarm irq", int'(irq), 1);
    reg_rd(8'h0C, v);
    chk("R9 alarm flag", v & 8'hA0, 8'hA0);
    chk("R10 alarm irq cleared", int'(irq), 0);

    // R9 periodic
    reg_wr(8'h0B, 8'hC0);
    repeat (PLIM + 3) @(negedge clk);
    chk("R9 periodic irq", int'(irq), 1);
    reg_wr(8'h0B, 8'h80);
    reg_rd(8'h0C, v);
    chk("R9 periodic flag", v & 8'h40, 8'h40);

    // R12 flag byte write ignored
    reg_rd(8'h0C, v);
    reg_wr(8'h0C, 8'hB0);
    reg_rd(8'h0C, v);
    chk("R12 flag write ignored", v & 8'hB0, 8'h00);

    // R13: reset keeps store, clears index and irq
    mg_wr(8'h20, 8'h5A);
    reg_wr(8'h0B, 8'hD0);
    repeat (PLIM + 3) @(negedge clk);
    io_write(1'b0, 8'h33);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 irq cleared", int'(irq), 0);
    io_read(1'b0, v);
    chk("R13 index cleared", v, 0);
    reg_rd(8'h20, v);
    chk("R13 store kept", v, 8'h5A);
    reg_rd(8'h0B, v);
    chk("R13 control kept", v, 8'hD0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule